// File: doc/BRIEF.md
# Column Driver Input Loader

This block is the digital front end of a six-channel display column driver. Pixel words arrive on one shared 10-bit bus. Each word goes into the first-stage register of one channel. The channel is chosen in one of two ways:

- **Addressed mode:** a 3-bit channel address names the channel, and a chip-select input enables the load.
- **Sequenced mode:** an internal walker starts on a pulse and then steps through the channels, upward or downward.

An edge-select input picks which clock edge performs these captures.

A transfer request is sampled on the rising clock edge. On the falling edge that follows, all six first-stage words are copied at once into the second stage. The second stage drives the six held output words, so new words can be loaded while the current line is still on the outputs. A standby input freezes every update, and a synchronous reset clears everything.

Top module: `col_input_loader`

## Requirements
- R1: A synchronous reset clears all first-stage and second-stage words to zero and leaves the sequencer idle. Channel c appears on `heldWords[c*10+9 : c*10]`, with bit 9 of each word as the MSB.
- R2: Loading words into the first stage never changes `heldWords` until a transfer commits.
- R3: With `edgeSel` high, captures happen on the rising clock edge; with `edgeSel` low, on the falling edge. `edgeSel` may only change while `stby` is high.
- R4: At a capture edge, `chanAddr` 0 to 5 with `startCs` high loads `dataIn` into that channel. With `startCs` low, no channel changes.
- R5: `chanAddr` 6 loads no channel, even with `startCs` high.
- R6: `chanAddr` 7 selects sequenced loading. A capture edge with `startCs` high does two things: it loads `dataIn` into the start channel (0 when `dirSel` is low, 5 when it is high), and it begins a run. Each later capture edge loads the next channel, one step up for low `dirSel` or down for high `dirSel`. The direction is fixed at the start.
- R7: After the run loads its last channel (5 going up, 0 going down), further sequenced words are ignored until the next start pulse.
- R8: A start pulse during a run restarts it from the start channel of the current `dirSel`.
- R9: If `xfr` is high at a rising clock edge, all six first-stage words are copied into `heldWords` at the following falling edge, and not earlier.
- R10: While `stby` is high, no first-stage word changes, the sequencer does not move and no transfer commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 10 | Pixel word bus |
| edgeSel | input | 1 | Capture edge: 1 rising, 0 falling |
| dirSel | input | 1 | Sequencer direction: 0 up, 1 down |
| chanAddr | input | 3 | Channel address; 7 selects sequenced mode |
| startCs | input | 1 | Chip-select (addressed) or start pulse (sequenced) |
| xfr | input | 1 | Transfer request, sampled on rising edge |
| stby | input | 1 | Standby: freezes all updates |
| heldWords | output | 60 | Six second-stage words, channel c at bits c*10+9..c*10 |

## Verification
For each capture edge, the bench fills all six channels by address with arithmetically distinct words, and also issues reserved-address and deselected loads. A missing chip-select gate or a reserved-code load would overwrite a known word. Full upward and downward runs with one surplus word show whether the channel order is mirrored and whether the run stops at its end. A run that is restarted mid-way with the direction flipped separates restart from continuation. A probe that changes the bus between the rising and falling edges shows which edge captured. Transfers are checked between arming and commit, and during standby, to expose an early or ungated copy.

// File: rtl/col_loader_pkg.sv
package col_loader_pkg;
  localparam int CH_COUNT = 6;

  typedef struct packed {
    logic [CH_COUNT-1:0] loadMask;
    logic                commit;
  } ldr_strobe_t;
endpackage

// File: rtl/ldr_ctrl.sv
module ldr_ctrl
  import col_loader_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              capClk,
  input  logic              rst,
  input  logic              stby,
  input  logic [ADDR_W-1:0] chanAddr,
  input  logic              startCs,
  input  logic              dirSel,
  input  logic              xfr,
  output ldr_strobe_t       strobe
);
  localparam int PTR_W = $clog2(CH_COUNT);
  localparam logic [ADDR_W-1:0] SEQ_CODE = {ADDR_W{1'b1}};
  localparam logic [PTR_W-1:0] TOP_CH = PTR_W'(CH_COUNT - 1);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic             seqActive, seqDownQ, xfrArmed;
  logic [PTR_W-1:0] seqPtr;
  logic             seqMode, loadValid;
  logic [PTR_W-1:0] loadCh, startCh, lastCh;

  assign seqMode = (chanAddr == SEQ_CODE);
  assign startCh = dirSel ? TOP_CH : '0;
  assign lastCh  = seqDownQ ? '0 : TOP_CH;

  always_comb begin
    loadValid = 1'b0;
    loadCh    = '0;
    if (!stby) begin
      if (seqMode) begin
        if (startCs) begin
          loadValid = 1'b1;
          loadCh    = startCh;
        end else if (seqActive) begin
          loadValid = 1'b1;
          loadCh    = seqPtr;
        end
      end else if (startCs && chanAddr < ADDR_W'(CH_COUNT)) begin
        loadValid = 1'b1;
        loadCh    = PTR_W'(chanAddr);
      end
    end
    for (int i = 0; i < CH_COUNT; i++) begin
      strobe.loadMask[i] = loadValid && (loadCh == PTR_W'(i));
    end
    strobe.commit = xfrArmed && !stby;
  end

  always_ff @(posedge capClk) begin
    if (rst) begin
      seqActive <= 1'b0;
      seqDownQ  <= 1'b0;
      seqPtr    <= '0;
    end else if (!stby && seqMode) begin
      if (startCs) begin
        seqActive <= 1'b1;
        seqDownQ  <= dirSel;
        seqPtr    <= dirSel ? startCh - ONE : startCh + ONE;
      end else if (seqActive) begin
        if (seqPtr == lastCh) seqActive <= 1'b0;
        else seqPtr <= seqDownQ ? seqPtr - ONE : seqPtr + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) xfrArmed <= 1'b0;
    else     xfrArmed <= xfr;
  end

  assert_seq_ptr_range_R6: assert property (@(posedge capClk) disable iff (rst)
    seqActive |-> (seqPtr <= TOP_CH));
  assert_single_load_R4: assert property (@(posedge capClk) disable iff (rst)
    $onehot0(strobe.loadMask));
  assert_reserved_silent_R5: assert property (@(posedge capClk) disable iff (rst)
    (!seqMode && chanAddr >= ADDR_W'(CH_COUNT)) |-> (strobe.loadMask == '0));
  assert_run_stops_R7: assert property (@(posedge capClk) disable iff (rst)
    (seqActive && seqMode && !startCs && !stby && seqPtr == lastCh) |=> !seqActive);
endmodule

// File: rtl/ldr_datapath.sv
module ldr_datapath
  import col_loader_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                       clk,
  input  logic                       capClk,
  input  logic                       rst,
  input  logic                       stby,
  input  logic [DATA_W-1:0]          dataIn,
  input  ldr_strobe_t                strobe,
  output logic [CH_COUNT*DATA_W-1:0] heldWords
);
  logic [CH_COUNT-1:0][DATA_W-1:0] stage1, stage2;

  for (genvar c = 0; c < CH_COUNT; c++) begin : gChan
    always_ff @(posedge capClk) begin
      if (rst) stage1[c] <= '0;
      else if (strobe.loadMask[c]) stage1[c] <= dataIn;
    end

    always_ff @(negedge clk) begin
      if (rst) stage2[c] <= '0;
      else if (strobe.commit) stage2[c] <= stage1[c];
    end
  end

  assign heldWords = stage2;

  assert_standby_freeze_R10: assert property (@(posedge capClk) disable iff (rst)
    stby |=> $stable(stage1));
  assert_commit_copies_R9: assert property (@(negedge clk) disable iff (rst)
    strobe.commit |=> (stage2 == $past(stage1)));
  assert_hold_between_R2: assert property (@(negedge clk) disable iff (rst)
    !strobe.commit |=> $stable(stage2));
endmodule

// File: rtl/col_input_loader.sv
module col_input_loader
  import col_loader_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [DATA_W-1:0]          dataIn,
  input  logic                       edgeSel,
  input  logic                       dirSel,
  input  logic [ADDR_W-1:0]          chanAddr,
  input  logic                       startCs,
  input  logic                       xfr,
  input  logic                       stby,
  output logic [CH_COUNT*DATA_W-1:0] heldWords
);
  logic        capClk;
  ldr_strobe_t strobe;

  assign capClk = clk ^ ~edgeSel;

  ldr_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .capClk(capClk), .rst(rst), .stby(stby), .chanAddr(chanAddr),
    .startCs(startCs), .dirSel(dirSel), .xfr(xfr), .strobe(strobe)
  );

  ldr_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .capClk(capClk), .rst(rst), .stby(stby), .dataIn(dataIn),
    .strobe(strobe), .heldWords(heldWords)
  );
endmodule

// File: tb/sim_col_input_loader.sv
module sim_col_input_loader;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst, edgeSel, dirSel, startCs, xfr, stby;
  logic [9:0]  dataIn;
  logic [2:0]  chanAddr;
  logic [59:0] heldWords;
  int          checks = 0, failures = 0;
  bit          done = 0;
  logic [9:0]  want[6];
  logic [9:0]  shown[6];

  always #(CLK_P/2) clk = ~clk;

  col_input_loader u0 (
    .clk(clk), .rst(rst), .dataIn(dataIn), .edgeSel(edgeSel), .dirSel(dirSel),
    .chanAddr(chanAddr), .startCs(startCs), .xfr(xfr), .stby(stby), .heldWords(heldWords)
  );

  task automatic checkAll(input logic [9:0] exp[6], input string tag);
    for (int c = 0; c < 6; c++) begin
      checks++;
      if (heldWords[c*10 +: 10] !== exp[c]) begin
        failures++;
        $display("FAIL %s ch%0d got=%0d expected=%0d", tag, c, heldWords[c*10 +: 10], exp[c]);
      end
    end
  endtask

  task automatic capEdge();
    if (edgeSel) @(posedge clk); else @(negedge clk);
    #1;
  endtask

  task automatic load(input int d, input int a, input bit cs);
    dataIn = 10'(d); chanAddr = 3'(a); startCs = cs;
    capEdge();
    startCs = 0; chanAddr = 3'd6;
  endtask

  // R9: armed at rising edge, visible only after the following falling edge
  task automatic doXfer(input bit expectCommit, input string tag);
    checkAll(shown, {"R2 ", tag});
    @(negedge clk); #1; xfr = 1;
    @(posedge clk); #1; xfr = 0;
    checkAll(shown, {"R9 pre-commit ", tag});
    @(negedge clk); #1;
    if (expectCommit) shown = want;
    checkAll(shown, {"R9 commit ", tag});
  endtask

  task automatic setEdge(input bit e);
    stby = 1;
    @(posedge clk); @(negedge clk); #1;
    edgeSel = e;
    @(posedge clk); @(negedge clk); #1;
    stby = 0;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; edgeSel = 0; dirSel = 0; startCs = 0; xfr = 0; stby = 0;
    dataIn = 0; chanAddr = 3'd6;
    for (int c = 0; c < 6; c++) begin want[c] = 0; shown[c] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst = 0;
    checkAll(shown, "R1 reset");
    load(0, 7, 0);  // R1: sequencer idle after reset, word ignored
    doXfer(1, "R1 idle");

    for (int mode = 0; mode < 2; mode++) begin
      setEdge(mode[0]);
      // R4 addressed sweep, R5 reserved code, deselected load
      for (int a = 0; a < 6; a++) begin
        want[a] = 10'((a * 173 + mode * 311 + 5) % 1024);
        load(want[a], a, 1);
      end
      load(1023, 6, 1);
      load(77, 2, 0);
      doXfer(1, "R4 R5");

      // R6/R7 full runs both directions with one surplus word
      for (int dir = 0; dir < 2; dir++) begin
        dirSel = dir[0];
        for (int k = 0; k < 6; k++) begin
          int ch;
          ch = dir ? 5 - k : k;
          want[ch] = 10'((k * 59 + dir * 400 + mode * 13 + 100) % 1024);
          load(want[ch], 7, k == 0);
        end
        load(999, 7, 0);
        doXfer(1, "R6 R7");
      end

      // R8 restart mid-run with direction flipped
      dirSel = 0;
      for (int k = 0; k < 3; k++) begin
        want[k] = 10'(700 + k + mode * 50);
        load(want[k], 7, k == 0);
      end
      dirSel = 1;
      for (int k = 0; k < 6; k++) begin
        want[5 - k] = 10'(10 + k * 3 + mode * 90);
        load(want[5 - k], 7, k == 0);
      end
      load(888, 7, 0);
      doXfer(1, "R8 restart");

      // R3 edge probe: A present at rising edge, B at falling edge
      @(negedge clk); #1; dataIn = 10'd321; chanAddr = 3'd3; startCs = 1;
      @(posedge clk); #1; dataIn = 10'd654;
      @(negedge clk); #1; startCs = 0; chanAddr = 3'd6;
      want[3] = mode ? 10'd321 : 10'd654;
      doXfer(1, "R3 edge");
    end

    // R10 standby: loads, start pulse and commit frozen
    want[1] = 10'd500;
    load(500, 1, 1);
    stby = 1;
    doXfer(0, "R10 commit frozen");
    load(11, 0, 1);
    dirSel = 0;
    load(22, 7, 1);
    stby = 0;
    load(33, 7, 0);
    doXfer(1, "R10 release");
    checkAll(want, "R10 loads frozen");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule